// File: doc/BRIEF.md
# Fetch Address Sequencer with Single-Level Subroutine Return

This block produces the instruction fetch address of a small in-order processor. Each cycle it takes the decoded class of the instruction at the current fetch address and picks the next fetch address from four sources:

- a late correction address,
- a saved return address,
- an absolute target carried in the instruction,
- the current address plus one.

The chosen address is registered and becomes the new fetch address on the next clock edge.

A subroutine call does two things: it moves fetch to its target, and it records the address just after the call in one return register. A return moves fetch back to that recorded address. Jumps never touch the return register, whether they are conditional or not. A conditional jump carries a static hint bit. When the hint is set, fetch goes to the target at once. When the hint is clear, fetch keeps stepping linearly. The execute stage resolves mispredictions later and corrects them through the redirect port. Only one call level can be outstanding, because a second call replaces the saved address.

Top module: `progSequencer`

## Requirements
- R1: With instruction class 0 (none), or any of the unused codes 5 to 7, and no redirect, the fetch address after the next clock edge is the current one plus one, wrapping from all-ones to zero.
- R2: Class 1 (unconditional jump) loads the target field into the fetch address at the next edge, whatever the hint bit is, and leaves the return register unchanged.
- R3: Class 3 (call) loads the target field into the fetch address and writes the current fetch address plus one into the return register, both at the next edge.
- R4: Class 4 (return) loads the return register's value into the fetch address at the next edge, and the target field has no effect.
- R5: Class 2 (conditional jump) goes to the target when the hint bit is 1 and to the current address plus one when it is 0. In both cases the return register is left unchanged.
- R6: An asserted redirect loads the redirect address at the next edge, overriding every other source. The instruction it squashes has no effect, so a call in that cycle does not write the return register.
- R7: A second call issued before a return overwrites the return register, so a later return goes to the address after the most recent call.
- R8: While reset is low, the fetch address is 0 and the return register is 0.
- R9: The hint bit has no effect on any class other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opClass | input | 3 | Decoded class of the instruction at the current fetch address: 0 none, 1 jump, 2 conditional jump, 3 call, 4 return |
| targetAddr | input | ADDR_W | Absolute target carried in the instruction |
| predictTaken | input | 1 | Static taken hint for conditional jumps |
| redirValid | input | 1 | Late correction request from the execute stage |
| redirAddr | input | ADDR_W | Corrected fetch address |
| fetchPc | output | ADDR_W | Current fetch address |
| retAddr | output | ADDR_W | Current value of the return register |

## Verification
Every result of this block is due exactly one clock edge after its stimulus, because both the fetch address and the return register are single registers fed by the next-address selection. The bench applies each stimulus on a falling edge and samples both outputs on the following falling edge, which is after the one rising edge that commits them. Reset values are sampled while reset is held low. Each table row's expected values are carried forward from the previous row, so return-register state that one row sets up is checked by later rows.

// File: rtl/seqPkg.sv
package seqPkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_JCOND = 3'd2,
    OP_CALL  = 3'd3,
    OP_RTS   = 3'd4
  } opClassE;

  // Strobes from control to datapath: exactly one next-address source
  // per cycle, plus the return-register write enable.
  typedef struct packed {
    logic takeRedir;
    logic takeReturn;
    logic takeTarget;
    logic takeLinear;
    logic saveReturn;
  } seqStrobeT;

endpackage

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opClass,
  input  logic       predictTaken,
  input  logic       redirValid,
  output seqStrobeT  strobes
);

  logic isJump;
  logic isCondTaken;
  logic isCall;
  logic isReturn;

  always_comb begin
    isJump      = 1'b0;
    isCondTaken = 1'b0;
    isCall      = 1'b0;
    isReturn    = 1'b0;
    case (opClass)
      OP_JUMP:  isJump      = 1'b1;
      OP_JCOND: isCondTaken = predictTaken;
      OP_CALL:  isCall      = 1'b1;
      OP_RTS:   isReturn    = 1'b1;
      default:  ;
    endcase
  end

  // Priority: redirect, return, target (jump/call/predicted branch), linear.
  always_comb begin
    strobes            = '0;
    if (redirValid) begin
      strobes.takeRedir  = 1'b1;
    end else if (isReturn) begin
      strobes.takeReturn = 1'b1;
    end else if (isJump || isCondTaken || isCall) begin
      strobes.takeTarget = 1'b1;
      strobes.saveReturn = isCall;
    end else begin
      strobes.takeLinear = 1'b1;
    end
  end

  // R6: the datapath is steered by exactly one source every cycle
  a_r6_single_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({strobes.takeRedir, strobes.takeReturn, strobes.takeTarget, strobes.takeLinear}));

  // R6: a squashed call never writes the return register
  a_r6_no_save_on_redir: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> !strobes.saveReturn);

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobes,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [ADDR_W-1:0] redirAddr,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] retAddr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] retReg;
  logic [ADDR_W-1:0] linearPc;
  logic [ADDR_W-1:0] nextPc;

  assign linearPc = pcReg + ONE;

  always_comb begin
    nextPc = linearPc;
    unique case (1'b1)
      strobes.takeRedir:  nextPc = redirAddr;
      strobes.takeReturn: nextPc = retReg;
      strobes.takeTarget: nextPc = targetAddr;
      default:            nextPc = linearPc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg <= RESET_PC;
    end else begin
      pcReg <= nextPc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retReg <= '0;
    end else if (strobes.saveReturn) begin
      retReg <= linearPc;
    end
  end

  assign fetchPc = pcReg;
  assign retAddr = retReg;

  // R1: linear stepping advances by exactly one
  a_r1_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeLinear |=> pcReg == $past(pcReg) + ONE);

  // R2/R5: return register only changes when the control asks for it
  a_r5_ret_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.saveReturn |=> $stable(retReg));

endmodule

// File: rtl/progSequencer.sv
module progSequencer
  import seqPkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opClass,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              predictTaken,
  input  logic              redirValid,
  input  logic [ADDR_W-1:0] redirAddr,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] retAddr
);

  seqStrobeT strobes;

  seqControl i_seqControl (
    .clk          (clk),
    .rstN         (rstN),
    .opClass      (opClass),
    .predictTaken (predictTaken),
    .redirValid   (redirValid),
    .strobes      (strobes)
  );

  seqDatapath #(
    .ADDR_W   (ADDR_W),
    .RESET_PC ('0)
  ) i_seqDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .targetAddr (targetAddr),
    .redirAddr  (redirAddr),
    .fetchPc    (fetchPc),
    .retAddr    (retAddr)
  );

  // R3: call lands on its target and records the following address
  a_r3_call_target: assert property (@(posedge clk) disable iff (!rstN)
    (opClass == OP_CALL && !redirValid) |=> fetchPc == $past(targetAddr));
  a_r3_call_saves: assert property (@(posedge clk) disable iff (!rstN)
    (opClass == OP_CALL && !redirValid) |=> retAddr == $past(fetchPc) + ADDR_W'(1));

  // R4: return resumes at the saved address
  a_r4_return: assert property (@(posedge clk) disable iff (!rstN)
    (opClass == OP_RTS && !redirValid) |=> fetchPc == $past(retAddr));

  // R2: unconditional jump leaves the return register alone
  a_r2_jump_keeps_ret: assert property (@(posedge clk) disable iff (!rstN)
    (opClass == OP_JUMP || opClass == OP_JCOND) |=> $stable(retAddr));

  // R6: redirect wins over everything
  a_r6_redirect: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> fetchPc == $past(redirAddr));

  // R8: reset state
  a_r8_reset: assert property (@(negedge clk) !rstN |-> (fetchPc == '0 && retAddr == '0));

endmodule

// File: tb/test_progSequencer.sv
`timescale 1ns/1ps
module test_progSequencer;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    opClass = 3'd0;
  logic [AW-1:0] targetAddr = '0;
  logic          predictTaken = 1'b0;
  logic          redirValid = 1'b0;
  logic [AW-1:0] redirAddr = '0;
  logic [AW-1:0] fetchPc;
  logic [AW-1:0] retAddr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  progSequencer #(.ADDR_W(AW)) i_progSequencer (
    .clk(clk), .rstN(rstN), .opClass(opClass), .targetAddr(targetAddr),
    .predictTaken(predictTaken), .redirValid(redirValid), .redirAddr(redirAddr),
    .fetchPc(fetchPc), .retAddr(retAddr)
  );

  typedef struct packed {
    logic [2:0]    op;
    logic [AW-1:0] tgt;
    logic          pred;
    logic          rd;
    logic [AW-1:0] rdAddr;
    logic [AW-1:0] expPc;
    logic [AW-1:0] expRet;
    logic [3:0]    req;
  } vecT;

  localparam int NVEC = 14;
  localparam vecT VECS [NVEC] = '{
    '{3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0001, 16'h0000, 4'd1}, // R1 step
    '{3'd0, 16'h0050, 1'b1, 1'b0, 16'h0000, 16'h0002, 16'h0000, 4'd9}, // R9 hint on none
    '{3'd1, 16'h0100, 1'b0, 1'b0, 16'h0000, 16'h0100, 16'h0000, 4'd2}, // R2 jump, hint 0
    '{3'd3, 16'h0200, 1'b0, 1'b0, 16'h0000, 16'h0200, 16'h0101, 4'd3}, // R3 call
    '{3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0201, 16'h0101, 4'd1}, // R1 step
    '{3'd2, 16'h0300, 1'b0, 1'b0, 16'h0000, 16'h0202, 16'h0101, 4'd5}, // R5 not hinted
    '{3'd2, 16'h0300, 1'b1, 1'b0, 16'h0000, 16'h0300, 16'h0101, 4'd5}, // R5 hinted
    '{3'd4, 16'h0999, 1'b0, 1'b0, 16'h0000, 16'h0101, 16'h0101, 4'd4}, // R4 return
    '{3'd3, 16'h0400, 1'b0, 1'b0, 16'h0000, 16'h0400, 16'h0102, 4'd3}, // R3 call
    '{3'd3, 16'h0500, 1'b0, 1'b0, 16'h0000, 16'h0500, 16'h0401, 4'd7}, // R7 overwrite
    '{3'd4, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0401, 16'h0401, 4'd7}, // R7 return to newest
    '{3'd3, 16'h0800, 1'b0, 1'b1, 16'h0700, 16'h0700, 16'h0401, 4'd6}, // R6 squashed call
    '{3'd4, 16'h0000, 1'b0, 1'b1, 16'h0710, 16'h0710, 16'h0401, 4'd6}, // R6 over return
    '{3'd6, 16'h0020, 1'b1, 1'b0, 16'h0000, 16'h0711, 16'h0401, 4'd1}  // R1 unused code
  };

  task automatic check(input string tag, input logic [AW-1:0] actPc, input logic [AW-1:0] expPc,
                       input logic [AW-1:0] actRet, input logic [AW-1:0] expRet);
    testsRun++;
    if (actPc !== expPc || actRet !== expRet) begin
      testsFailed++;
      $display("FAIL %s: pc=%h ret=%h expected pc=%h ret=%h", tag, actPc, actRet, expPc, expRet);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [AW-1:0] tgt, input logic pred,
                       input logic rd, input logic [AW-1:0] ra);
    opClass = op; targetAddr = tgt; predictTaken = pred; redirValid = rd; redirAddr = ra;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset values", fetchPc, '0, retAddr, '0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].op, VECS[i].tgt, VECS[i].pred, VECS[i].rd, VECS[i].rdAddr);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), fetchPc, VECS[i].expPc, retAddr, VECS[i].expRet);
    end

    // R1 wrap from all-ones to zero
    drive(3'd1, 16'hFFFF, 1'b1, 1'b0, '0);
    @(negedge clk);
    check("R2 jump to top, hint 1", fetchPc, 16'hFFFF, retAddr, 16'h0401);
    drive(3'd0, '0, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R1 wrap", fetchPc, 16'h0000, retAddr, 16'h0401);

    // R3 call at the top address saves the wrapped follower
    drive(3'd1, 16'hFFFF, 1'b0, 1'b0, '0);
    @(negedge clk);
    drive(3'd3, 16'h0040, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R3 call saves wrapped address", fetchPc, 16'h0040, retAddr, 16'h0000);

    // R8 reset in mid-run
    drive(3'd0, '0, 1'b0, 1'b0, '0);
    @(negedge clk);
    drive(3'd3, 16'h0123, 1'b0, 1'b0, '0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R8 mid-run reset", fetchPc, '0, retAddr, '0);
    @(negedge clk);
    drive(3'd0, '0, 1'b0, 1'b0, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 step after reset", fetchPc, 16'h0001, retAddr, 16'h0000);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule